// File: doc/BRIEF.md
# Inbound DMA Buffer Closure and Gap Flush Controller

This block sits between a host-side byte port and the receive DMA channel of an inbound byte stream. It packs arriving bytes into 32-bit words for a FIFO and decides when the current DMA buffer should be closed. Two closure rules run side by side, both set from one 32-bit limits register.

The first rule is based on size. A 16-bit running count grows by the byte count of every DMA transfer and is cleared when a DMA operation completes. When the count meets or passes the programmed maximum, the block requests a buffer close and sets a sticky interrupt flag. The interrupt output is gated by a mask bit.

The second rule is based on idle time. A 16-bit counter measures the clock cycles since the host last delivered a byte. When it reaches the programmed timeout while the packer holds a partial word, that word is pushed to the FIFO early, together with a count of its valid bytes.

Top module: `bufclose_ctl`

## Requirements
- R1: After reset both registers read as zero, and `fifo_wr`, `close_req` and `irq` are low.
- R2: Register address 0 holds the limits. Bits 31:16 are the maximum buffer size in bytes and bits 15:0 are the gap timeout in clock cycles. Both fields are read/write and can be read back through `reg_rdata`.
- R3: Bytes taken while `byte_vld` is high are packed little-endian, with the first byte in bits 7:0. The fourth byte produces a FIFO write with `fifo_cnt` = 4 in the cycle after that byte is taken.
- R4: Each cycle without a byte adds one to the gap counter, and a byte clears it. When the counter reaches a nonzero timeout while 1 to 3 bytes are held, the held bytes are written once with `fifo_cnt` equal to their number and the unused upper lanes set to zero. The write appears in the cycle after the idle cycle in which the counter reaches the timeout.
- R5: A gap timeout of zero never causes a flush, and an empty packer is never flushed.
- R6: The buffer count adds `xfer_bytes` on each cycle with `xfer_vld` high and saturates at 0xFFFF. It clears on a cycle with `dma_done` high, and `dma_done` wins over a transfer in the same cycle.
- R7: `close_req` is high whenever the maximum buffer size is nonzero and the buffer count is at or above it. A maximum of zero keeps it low.
- R8: Register address 1 holds the interrupt flag in bit 0 and the interrupt mask in bit 1. The flag is set when a transfer carries the count from below a nonzero maximum to at or above it. It stays set until a 1 is written to bit 0, and a set in the same cycle wins over the clear. `irq` equals the flag ANDed with the mask.
- R9: The gap counter saturates at 0xFFFF instead of wrapping, so an idle period produces at most one flush, including with a timeout of 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byte_vld | input | 1 | A byte is taken from the host this cycle |
| byte_in | input | 8 | Byte value |
| xfer_vld | input | 1 | The DMA channel moves data this cycle |
| xfer_bytes | input | 3 | Bytes moved by this transfer |
| dma_done | input | 1 | The DMA operation completes this cycle |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 limits, 1 interrupt |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data for the selected register |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_data | output | 32 | Packed word, little-endian lanes |
| fifo_cnt | output | 3 | Valid bytes in the word (1 to 4) |
| close_req | output | 1 | Request to close the current DMA buffer |
| irq | output | 1 | Masked maximum-size interrupt |

## Verification
The hardest case to reach from the ports is the gap counter saturating and holding while a partial word waits. With a timeout of 0xFFFF, exactly one flush must occur, at the 65535th idle cycle, and nothing must follow. A directed run loads that timeout, feeds one byte and then idles for about seventy thousand cycles while counting FIFO writes. A second hard case is a size crossing that lands in the same cycle as a write-1 clear of the flag. It is built by pairing a transfer that reaches the maximum with the clear write. Random phases mix bursts and idle runs against small limits so that flushes of 1, 2 and 3 bytes, closes and completions interleave.

// File: rtl/bcc_pkg.sv
package bcc_pkg;
  // register select values
  localparam logic ADDR_LIMITS = 1'b0;
  localparam logic ADDR_IRQ    = 1'b1;
  // bit positions inside the interrupt register
  localparam int IRQ_FLAG_BIT  = 0;
  localparam int IRQ_MASK_BIT  = 1;
endpackage

// File: rtl/bcc_regs.sv
module bcc_regs
  import bcc_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic               reg_addr,
  input  logic [2*CNT_W-1:0] reg_wdata,
  input  logic               reach_pulse,
  output logic [CNT_W-1:0]   max_sz,
  output logic [CNT_W-1:0]   gap_lim,
  output logic [2*CNT_W-1:0] reg_rdata,
  output logic               irq
);
  localparam int RW = 2 * CNT_W;

  logic [RW-1:0] lim_q, lim_d;
  logic          flag_q, flag_d;
  logic          mask_q, mask_d;
  logic          lim_en, irq_en, flag_clr;

  always_comb begin
    lim_en   = reg_wr && (reg_addr == ADDR_LIMITS);
    irq_en   = reg_wr && (reg_addr == ADDR_IRQ);
    flag_clr = irq_en && reg_wdata[IRQ_FLAG_BIT];
    lim_d    = lim_en ? reg_wdata : lim_q;
    mask_d   = irq_en ? reg_wdata[IRQ_MASK_BIT] : mask_q;
    // a new crossing beats a simultaneous write-1 clear
    flag_d   = reach_pulse | (flag_q & ~flag_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q  <= '0;
      flag_q <= 1'b0;
      mask_q <= 1'b0;
    end else begin
      lim_q  <= lim_d;
      flag_q <= flag_d;
      mask_q <= mask_d;
    end
  end

  always_comb begin
    max_sz  = lim_q[RW-1:CNT_W];
    gap_lim = lim_q[CNT_W-1:0];
    irq     = flag_q & mask_q;
    if (reg_addr == ADDR_LIMITS) begin
      reg_rdata = lim_q;
    end else begin
      reg_rdata = '0;
      reg_rdata[IRQ_FLAG_BIT] = flag_q;
      reg_rdata[IRQ_MASK_BIT] = mask_q;
    end
  end

  // R8: a crossing always leaves the flag set
  a_r8_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    reach_pulse |=> flag_q);
  // R8: the flag is sticky until a write-1 clear
  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !(reg_wr && reg_addr == ADDR_IRQ && reg_wdata[IRQ_FLAG_BIT])) |=> flag_q);
  // R2: the limits hold their value when not written
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADDR_LIMITS) |=> $stable(lim_q));
endmodule

// File: rtl/bcc_bufcnt.sv
module bcc_bufcnt #(
  parameter int CNT_W = 16,
  parameter int XB_W  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             xfer_vld,
  input  logic [XB_W-1:0]  xfer_bytes,
  input  logic             dma_done,
  input  logic [CNT_W-1:0] max_sz,
  output logic             close_req,
  output logic             reach_pulse
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] bc_q, bc_d;
  logic [CNT_W:0]   sum;
  logic             lim_on;

  always_comb begin
    lim_on = (max_sz != '0);
    sum    = {1'b0, bc_q} + {{(CNT_W+1-XB_W){1'b0}}, xfer_bytes};
    if (dma_done) begin
      bc_d = '0;
    end else if (xfer_vld) begin
      bc_d = sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
    end else begin
      bc_d = bc_q;
    end
    reach_pulse = lim_on && (bc_q < max_sz) && (bc_d >= max_sz);
    close_req   = lim_on && (bc_q >= max_sz);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bc_q <= '0;
    end else if (dma_done || xfer_vld) begin
      bc_q <= bc_d;
    end
  end

  // R6: completion clears the count
  a_r6_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> (bc_q == '0));
  // R6: no transfer and no completion leaves the count unchanged
  a_r6_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_done && !xfer_vld) |=> $stable(bc_q));
  // R6: a transfer never lowers the count
  a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_vld && !dma_done) |=> (bc_q >= $past(bc_q)));
endmodule

// File: rtl/bcc_packer.sv
module bcc_packer #(
  parameter int WB    = 4,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             byte_vld,
  input  logic [7:0]       byte_in,
  input  logic [CNT_W-1:0] gap_lim,
  output logic             fifo_wr,
  output logic [8*WB-1:0]  fifo_data,
  output logic [$clog2(WB+1)-1:0] fifo_cnt
);
  localparam int CW = $clog2(WB + 1);
  localparam int DW = 8 * WB;
  localparam logic [CNT_W-1:0] GAP_MAX = '1;
  localparam logic [CW-1:0]    LAST    = CW'(WB - 1);
  localparam logic [CW-1:0]    FULL    = CW'(WB);

  logic [CW-1:0]    held_q, held_d;
  logic [DW-1:0]    word_q, word_d, word_fill;
  logic [CNT_W-1:0] gap_q, gap_d;
  logic             wr_q, wr_d;
  logic [DW-1:0]    data_q, data_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             reach, flush, full;

  // place the incoming byte into the lane selected by the held count
  for (genvar i = 0; i < WB; i++) begin : g_lane
    assign word_fill[8*i +: 8] = (byte_vld && held_q == CW'(i)) ? byte_in : word_q[8*i +: 8];
  end

  always_comb begin
    if (byte_vld) begin
      gap_d = '0;
    end else if (gap_q == GAP_MAX) begin
      gap_d = gap_q;
    end else begin
      gap_d = gap_q + 1'b1;
    end
    reach = !byte_vld && (gap_lim != '0) && (gap_q != gap_lim) && (gap_d == gap_lim);
    flush = reach && (held_q != '0);
    full  = byte_vld && (held_q == LAST);

    held_d = held_q;
    word_d = word_q;
    wr_d   = 1'b0;
    data_d = data_q;
    cnt_d  = cnt_q;
    if (full) begin
      wr_d   = 1'b1;
      data_d = word_fill;
      cnt_d  = FULL;
      held_d = '0;
      word_d = '0;
    end else if (byte_vld) begin
      word_d = word_fill;
      held_d = held_q + 1'b1;
    end else if (flush) begin
      wr_d   = 1'b1;
      data_d = word_q;
      cnt_d  = held_q;
      held_d = '0;
      word_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
      word_q <= '0;
      gap_q  <= '0;
      wr_q   <= 1'b0;
      data_q <= '0;
      cnt_q  <= '0;
    end else begin
      held_q <= held_d;
      word_q <= word_d;
      gap_q  <= gap_d;
      wr_q   <= wr_d;
      if (wr_d) begin
        data_q <= data_d;
        cnt_q  <= cnt_d;
      end
    end
  end

  assign fifo_wr   = wr_q;
  assign fifo_data = data_q;
  assign fifo_cnt  = cnt_q;

  // R4: every write carries 1..WB valid bytes
  a_r4_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr |-> (fifo_cnt != '0 && fifo_cnt <= FULL));
  // R4: a partial word is only written after an idle cycle
  a_r4_partial_after_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_wr && fifo_cnt != FULL) |-> !$past(byte_vld));
  // R5: an empty packer with no byte never writes
  a_r5_no_empty_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q == '0 && !byte_vld) |=> !fifo_wr);
  // R9: the gap counter holds at its ceiling
  a_r9_gap_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_q == GAP_MAX && !byte_vld) |=> (gap_q == GAP_MAX));
endmodule

// File: rtl/bufclose_ctl.sv
module bufclose_ctl #(
  parameter int CNT_W = 16,
  parameter int WB    = 4,
  parameter int XB_W  = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    byte_vld,
  input  logic [7:0]              byte_in,
  input  logic                    xfer_vld,
  input  logic [XB_W-1:0]         xfer_bytes,
  input  logic                    dma_done,
  input  logic                    reg_wr,
  input  logic                    reg_addr,
  input  logic [2*CNT_W-1:0]      reg_wdata,
  output logic [2*CNT_W-1:0]      reg_rdata,
  output logic                    fifo_wr,
  output logic [8*WB-1:0]         fifo_data,
  output logic [$clog2(WB+1)-1:0] fifo_cnt,
  output logic                    close_req,
  output logic                    irq
);
  logic [1:0]       rst_sync_q;
  logic             rst_n_i;
  logic [CNT_W-1:0] max_sz, gap_lim;
  logic             reach_pulse;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync_q[1];

  bcc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst_n(rst_n_i), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reach_pulse(reach_pulse), .max_sz(max_sz),
    .gap_lim(gap_lim), .reg_rdata(reg_rdata), .irq(irq)
  );

  bcc_bufcnt #(.CNT_W(CNT_W), .XB_W(XB_W)) u_bufcnt (
    .clk(clk), .rst_n(rst_n_i), .xfer_vld(xfer_vld), .xfer_bytes(xfer_bytes),
    .dma_done(dma_done), .max_sz(max_sz), .close_req(close_req),
    .reach_pulse(reach_pulse)
  );

  bcc_packer #(.WB(WB), .CNT_W(CNT_W)) u_packer (
    .clk(clk), .rst_n(rst_n_i), .byte_vld(byte_vld), .byte_in(byte_in),
    .gap_lim(gap_lim), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .fifo_cnt(fifo_cnt)
  );

  // R7: with a zero maximum, a close request never appears
  a_r7_zero_max: assert property (@(posedge clk) disable iff (!rst_n_i)
    (max_sz == '0) |-> !close_req);
  // R8: the interrupt only shows with the mask set
  a_r8_masked: assert property (@(posedge clk) disable iff (!rst_n_i)
    irq |-> reg_rdata[1] || reg_addr == 1'b0);
endmodule

// File: tb/bufclose_ctl_bench.sv
module bufclose_ctl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        byte_vld, xfer_vld, dma_done, reg_wr, reg_addr;
  logic [7:0]  byte_in;
  logic [2:0]  xfer_bytes;
  logic [31:0] reg_wdata, reg_rdata, fifo_data;
  logic        fifo_wr, close_req, irq;
  logic [2:0]  fifo_cnt;

  always #4 clk = ~clk;

  bufclose_ctl u_bufclose_ctl (
    .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_in(byte_in),
    .xfer_vld(xfer_vld), .xfer_bytes(xfer_bytes), .dma_done(dma_done),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .fifo_wr(fifo_wr), .fifo_data(fifo_data),
    .fifo_cnt(fifo_cnt), .close_req(close_req), .irq(irq)
  );

  int total = 0, bad = 0, wr_seen = 0;
  bit finished = 0;

  // reference state, built from the requirements
  logic [15:0] m_max, m_gap, m_bc, m_gcnt;
  logic        m_flag, m_mask;
  int          m_held;
  logic [31:0] m_word, e_data;
  logic        e_wr;
  logic [2:0]  e_cnt;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] sat_add(input logic [15:0] a, input logic [2:0] b);
    logic [16:0] s;
    s = {1'b0, a} + {14'd0, b};
    return s[16] ? 16'hFFFF : s[15:0];
  endfunction

  task automatic step(input logic bv, input logic [7:0] bd, input logic xv,
                      input logic [2:0] xb, input logic dn, input logic rw,
                      input logic ra, input logic [31:0] rd);
    logic [15:0] gd, bcd;
    logic        reach, setf, clrf;
    byte_vld = bv; byte_in = bd; xfer_vld = xv; xfer_bytes = xb;
    dma_done = dn; reg_wr = rw; reg_addr = ra; reg_wdata = rd;
    // packer and gap rule (R3, R4, R5, R9)
    gd    = bv ? 16'd0 : ((m_gcnt == 16'hFFFF) ? m_gcnt : m_gcnt + 16'd1);
    reach = !bv && (m_gap != 0) && (m_gcnt != m_gap) && (gd == m_gap);
    e_wr  = 1'b0;
    if (bv) begin
      m_word[8*m_held +: 8] = bd;
      if (m_held == 3) begin
        e_wr = 1'b1; e_data = m_word; e_cnt = 3'd4; m_held = 0; m_word = '0;
      end else begin
        m_held++;
      end
    end else if (reach && m_held != 0) begin
      e_wr = 1'b1; e_data = m_word; e_cnt = 3'(m_held); m_held = 0; m_word = '0;
    end
    m_gcnt = gd;
    // size rule (R6, R7, R8)
    bcd  = dn ? 16'd0 : (xv ? sat_add(m_bc, xb) : m_bc);
    setf = (m_max != 0) && (m_bc < m_max) && (bcd >= m_max);
    clrf = rw && ra && rd[0];
    m_flag = setf | (m_flag & !clrf);
    m_bc   = bcd;
    if (rw && !ra) begin m_max = rd[31:16]; m_gap = rd[15:0]; end
    if (rw && ra) m_mask = rd[1];
    @(posedge clk);
    @(negedge clk);
    if (fifo_wr) wr_seen++;
    if (e_wr) begin
      chk((e_cnt == 3'd4) ? "R3 wr" : "R4 wr", {31'd0, fifo_wr}, 32'd1);
      chk((e_cnt == 3'd4) ? "R3 data" : "R4 data", fifo_data, e_data);
      chk((e_cnt == 3'd4) ? "R3 cnt" : "R4 cnt", {29'd0, fifo_cnt}, {29'd0, e_cnt});
    end else begin
      chk("R5 no write", {31'd0, fifo_wr}, 32'd0);
    end
    chk("R7 close", {31'd0, close_req}, {31'd0, (m_max != 0) && (m_bc >= m_max)});
    chk("R8 irq", {31'd0, irq}, {31'd0, m_flag & m_mask});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 3'd0, 0, 0, 0, 32'd0);
  endtask

  task automatic wreg(input logic a, input logic [31:0] d);
    step(0, 8'h00, 0, 3'd0, 0, 1, a, d);
  endtask

  task automatic pushb(input logic [7:0] b);
    step(1, b, 0, 3'd0, 0, 0, 0, 32'd0);
  endtask

  task automatic xfer(input logic [2:0] n, input logic dn);
    step(0, 8'h00, 1, n, dn, 0, 0, 32'd0);
  endtask

  task automatic rd_chk(input string tag, input logic a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int w0;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    byte_vld = 0; byte_in = 0; xfer_vld = 0; xfer_bytes = 0; dma_done = 0;
    reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    m_max = 0; m_gap = 0; m_bc = 0; m_gcnt = 0; m_flag = 0; m_mask = 0;
    m_held = 0; m_word = 0; e_data = 0; e_wr = 0; e_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    chk("R1 fifo_wr", {31'd0, fifo_wr}, 32'd0);
    chk("R1 close_req", {31'd0, close_req}, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    rd_chk("R1 limits", 1'b0, 32'd0);
    rd_chk("R1 irq reg", 1'b1, 32'd0);

    // R2: field placement and readback
    wreg(1'b0, 32'h0010_0003);
    rd_chk("R2 readback", 1'b0, 32'h0010_0003);
    wreg(1'b0, 32'hA5C3_0000);
    rd_chk("R2 readback hi", 1'b0, 32'hA5C3_0000);

    // R3: four bytes, little-endian
    wreg(1'b0, 32'h0000_0000);
    pushb(8'h11); pushb(8'h22); pushb(8'h33); pushb(8'h44);
    chk("R3 full word", fifo_data, 32'h4433_2211);
    idle(3);

    // R4: partial flush of two bytes after three idle cycles, exactly once
    wreg(1'b0, 32'h0000_0003);
    pushb(8'hAB); pushb(8'hCD);
    w0 = wr_seen;
    idle(10);
    chk("R4 single flush", wr_seen - w0, 32'd1);
    // R4: flushes of one and three bytes
    pushb(8'h01); idle(5);
    pushb(8'h07); pushb(8'h08); pushb(8'h09); idle(5);

    // R5: zero timeout disables; empty packer never flushed
    wreg(1'b0, 32'h0000_0000);
    pushb(8'h5A);
    w0 = wr_seen;
    idle(30);
    chk("R5 zero timeout", wr_seen - w0, 32'd0);
    pushb(8'h5B); pushb(8'h5C); pushb(8'h5D);
    wreg(1'b0, 32'h0000_0002);
    w0 = wr_seen;
    idle(10);
    chk("R5 empty no flush", wr_seen - w0, 32'd0);

    // R6/R7: count, threshold and clear on completion
    wreg(1'b0, 32'h000A_0000);
    xfer(3'd4, 0); xfer(3'd4, 0);
    chk("R7 below max", {31'd0, close_req}, 32'd0);
    xfer(3'd2, 0);
    chk("R7 at max", {31'd0, close_req}, 32'd1);
    xfer(3'd4, 1);
    chk("R6 done wins", {31'd0, close_req}, 32'd0);
    xfer(3'd4, 0); xfer(3'd4, 0); xfer(3'd4, 0);
    chk("R7 above max", {31'd0, close_req}, 32'd1);
    step(0, 0, 0, 3'd0, 1, 0, 0, 32'd0);

    // R8: mask, sticky flag, write-1 clear, set beats clear
    rd_chk("R8 flag set", 1'b1, 32'd1);
    chk("R8 masked", {31'd0, irq}, 32'd0);
    wreg(1'b1, 32'd2);
    chk("R8 unmasked", {31'd0, irq}, 32'd1);
    wreg(1'b1, 32'd3);
    chk("R8 cleared", {31'd0, irq}, 32'd0);
    wreg(1'b0, 32'h0004_0000);
    step(0, 0, 1, 3'd4, 0, 1, 1, 32'd3);
    chk("R8 set beats clear", {31'd0, irq}, 32'd1);
    step(0, 0, 0, 3'd0, 1, 1, 1, 32'd3);

    // random phase mixing all rules
    for (int c = 0; c < 6000; c++) begin
      int r, dens;
      dens = ((c / 64) % 3 == 0) ? 90 : (((c / 64) % 3 == 1) ? 40 : 8);
      r = $urandom % 100;
      if (r < 2) begin
        wreg(1'b0, {16'($urandom % 48), 16'($urandom % 10)});
      end else if (r < 4) begin
        wreg(1'b1, {30'd0, 1'($urandom % 2), 1'($urandom % 2)});
      end else begin
        step(($urandom % 100) < dens, 8'($urandom), ($urandom % 4) == 0,
             3'(1 + $urandom % 4), ($urandom % 40) == 0, 0, 0, 32'd0);
      end
    end

    // R9: ceiling timeout, one byte held, long idle: exactly one flush
    wreg(1'b0, 32'h0000_FFFF);
    idle(2);
    pushb(8'hE7);
    w0 = wr_seen;
    idle(70000);
    chk("R9 one flush at ceiling", wr_seen - w0, 32'd1);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule